// File: doc/BRIEF.md
# Early-Prompt-Late Replica Correlator

This block turns one stream of replica code chips into three replica phases, early, prompt and late, spaced half a chip apart. It multiplies each phase by the sign bits of incoming 1-bit I and Q samples and sums the products over an integration period. A two-stage tap line moves once per half-chip tick. The live generator bit serves as the early replica, the first tap as prompt, and the second tap as late, which gives one chip between early and late. Each 1-bit product is a single XOR. A match adds +1 to a signed sum and a mismatch adds −1.

A dump strobe closes the integration period. The six sums, in-phase and quadrature for each of the three phases, are copied to the outputs and the sums restart from zero. A single-cycle valid pulse marks the new results. In dither mode one complex correlator serves early and late in turn. It follows the early replica in one period and the late replica in the next. A flag reports which of the two the delivered sum belongs to. This saves hardware, but each arm gets only half the integration energy.

Top module: `epl_correlator`

## Requirements
- R1: After reset all six sum outputs are 0, `dump_valid` is 0 and `late_arm` is 0.
- R2: The early replica is the current `code_bit`. Prompt is the value of `code_bit` captured at the most recent `half_tick`, and late is the value captured at the `half_tick` before that. The taps move only in cycles where `half_tick` is 1. A sample in the same cycle as a `half_tick` uses the taps as they were before the move.
- R3: In every cycle with `smp_en` at 1, each active sum gains +1 when its replica bit equals its sample sign bit and −1 when they differ. Sums whose name ends in `_i` use `i_sign`, and sums whose name ends in `_q` use `q_sign`. Cycles with `smp_en` at 0 change no sum.
- R4: In a cycle with `dump` at 1, the outputs take the running sums, including any sample taken in that same cycle. The running sums restart at 0, and in the next cycle `dump_valid` is 1 for exactly one cycle. The new output values appear in that same cycle.
- R5: Between dumps the sum outputs and `late_arm` keep their values.
- R6: With `dither_en` at 1, the early-slot sums (`early_i`, `early_q`) correlate the late replica if the internal arm is late, and the early replica otherwise. The late-slot sums are not updated, and at a dump they are delivered as 0. The prompt sums are unaffected.
- R7: The internal arm is 0 (early) after reset and whenever `dither_en` is 0. With `dither_en` at 1 it flips at every dump. At a dump, `late_arm` takes the arm used during the period just closed, or 0 if `dither_en` is 0.
- R8: Sums hold any value from −MAX_LEN to +MAX_LEN without wrapping, so MAX_LEN matching samples deliver exactly +MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe |
| half_tick | input | 1 | Advance replica taps (twice per chip) |
| code_bit | input | 1 | Replica chip from the code generator |
| i_sign | input | 1 | Sign of in-phase sample |
| q_sign | input | 1 | Sign of quadrature sample |
| dump | input | 1 | End of integration period |
| dither_en | input | 1 | Share one correlator between early and late |
| early_i | output | ACC_W | Early (or shared) in-phase sum |
| early_q | output | ACC_W | Early (or shared) quadrature sum |
| prompt_i | output | ACC_W | Prompt in-phase sum |
| prompt_q | output | ACC_W | Prompt quadrature sum |
| late_i | output | ACC_W | Late in-phase sum |
| late_q | output | ACC_W | Late quadrature sum |
| dump_valid | output | 1 | One-cycle pulse: new sums present |
| late_arm | output | 1 | Shared sum came from the late replica |

## Verification
Each sample and each tap move takes effect at the clock edge where it is presented. A dump takes effect at the same edge, so the delivered sums, `late_arm` and `dump_valid` all change after one edge. The bench applies stimulus at the falling edge, updates its arithmetic model for that one rising edge, and compares every output at the following falling edge. Outputs are therefore checked every cycle, both when they must change and when they must hold. Random chip, sign, tick and dump patterns cover short and long periods. Directed runs exercise a lone chip edge through the taps, arm alternation in dither mode and both extremes of the sum range.

// File: rtl/epl_correlator.sv
module epl_correlator #(
  parameter int MAX_LEN = 4096,
  localparam int ACC_W = $clog2(MAX_LEN + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    half_tick,
  input  logic                    code_bit,
  input  logic                    i_sign,
  input  logic                    q_sign,
  input  logic                    dump,
  input  logic                    dither_en,
  output logic signed [ACC_W-1:0] early_i,
  output logic signed [ACC_W-1:0] early_q,
  output logic signed [ACC_W-1:0] prompt_i,
  output logic signed [ACC_W-1:0] prompt_q,
  output logic signed [ACC_W-1:0] late_i,
  output logic signed [ACC_W-1:0] late_q,
  output logic                    dump_valid,
  output logic                    late_arm
);

  logic [1:0] taps;
  logic       arm;
  logic [2:0] rep;
  logic signed [ACC_W-1:0] run [6];
  logic signed [ACC_W-1:0] nxt [6];
  logic signed [ACC_W-1:0] held [6];

  assign rep[0] = dither_en ? (arm ? taps[1] : code_bit) : code_bit;
  assign rep[1] = taps[0];
  assign rep[2] = taps[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps <= '0;
      arm  <= 1'b0;
      late_arm <= 1'b0;
      dump_valid <= 1'b0;
    end else begin
      if (half_tick) taps <= {taps[0], code_bit};
      arm <= dither_en ? (arm ^ dump) : 1'b0;
      if (dump) late_arm <= dither_en & arm;
      dump_valid <= dump;
    end
  end

  for (genvar k = 0; k < 6; k++) begin : g_arm
    localparam int PH = k / 2;
    localparam bit QS = (k % 2) == 1;
    logic sgn, act;
    assign sgn = QS ? q_sign : i_sign;
    assign act = smp_en && !(dither_en && PH == 2);
    assign nxt[k] = !act ? run[k]
                  : (rep[PH] == sgn) ? run[k] + ACC_W'(1) : run[k] - ACC_W'(1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run[k]  <= '0;
        held[k] <= '0;
      end else if (dump) begin
        run[k]  <= '0;
        held[k] <= (dither_en && PH == 2) ? '0 : nxt[k];
      end else begin
        run[k]  <= nxt[k];
      end
    end
  end

  assign early_i  = held[0];
  assign early_q  = held[1];
  assign prompt_i = held[2];
  assign prompt_q = held[3];
  assign late_i   = held[4];
  assign late_q   = held[5];

endmodule

// File: rtl/epl_correlator_chk.sv
module epl_correlator_chk #(
  parameter int MAX_LEN = 4096,
  localparam int ACC_W = $clog2(MAX_LEN + 1) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic dump,
  input logic dither_en,
  input logic signed [ACC_W-1:0] early_i,
  input logic signed [ACC_W-1:0] early_q,
  input logic signed [ACC_W-1:0] prompt_i,
  input logic signed [ACC_W-1:0] prompt_q,
  input logic signed [ACC_W-1:0] late_i,
  input logic signed [ACC_W-1:0] late_q,
  input logic dump_valid,
  input logic late_arm
);
  AST_VALID_FOLLOWS_DUMP: assert property (@(posedge clk) disable iff (!rst_n) dump |=> dump_valid); // R4
  AST_VALID_ONLY_AFTER_DUMP: assert property (@(posedge clk) disable iff (!rst_n) !dump |=> !dump_valid); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> ($stable(early_i) && $stable(prompt_q) && $stable(late_i) && $stable(late_arm))); // R5
  AST_DITHER_LATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dump && dither_en) |=> (late_i == 0 && late_q == 0)); // R6
  AST_ARM_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (dump && !dither_en) |=> !late_arm); // R7
  AST_SAME_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    dump_valid |-> (early_i[0] == early_q[0] && early_i[0] == prompt_i[0] && prompt_i[0] == prompt_q[0])); // R3
endmodule

bind epl_correlator epl_correlator_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .dump(dump), .dither_en(dither_en),
  .early_i(early_i), .early_q(early_q), .prompt_i(prompt_i), .prompt_q(prompt_q),
  .late_i(late_i), .late_q(late_q), .dump_valid(dump_valid), .late_arm(late_arm));

// File: tb/tb_epl_correlator.sv
`timescale 1ns/1ps
module tb_epl_correlator;
  localparam int ML = 64;
  localparam int W = $clog2(ML + 1) + 1;

  logic clk = 0, rst_n = 0;
  logic smp_en = 0, half_tick = 0, code_bit = 0, i_sign = 0, q_sign = 0, dump = 0, dither_en = 0;
  logic signed [W-1:0] early_i, early_q, prompt_i, prompt_q, late_i, late_q;
  logic dump_valid, late_arm;

  always #2 clk = ~clk;

  epl_correlator #(.MAX_LEN(ML)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int macc [6], mout [6];
  bit [1:0] msr;
  bit marm, marmo, mdv;

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "early_i", early_i, mout[0]);  chk(tag, "early_q", early_q, mout[1]);
    chk(tag, "prompt_i", prompt_i, mout[2]); chk(tag, "prompt_q", prompt_q, mout[3]);
    chk(tag, "late_i", late_i, mout[4]);    chk(tag, "late_q", late_q, mout[5]);
    chk(tag, "dump_valid", dump_valid, mdv); chk(tag, "late_arm", late_arm, marmo);
  endtask

  task automatic cyc(string tag, bit s, bit h, bit c, bit is, bit qs, bit d, bit di);
    bit [2:0] r;
    smp_en = s; half_tick = h; code_bit = c; i_sign = is; q_sign = qs; dump = d; dither_en = di;
    r[0] = di ? (marm ? msr[1] : c) : c;
    r[1] = msr[0]; r[2] = msr[1];
    for (int k = 0; k < 6; k++) begin
      int t;
      bit sg;
      sg = (k % 2) ? qs : is;
      t = macc[k];
      if (s && !(di && k >= 4)) t += (r[k/2] == sg) ? 1 : -1;
      if (d) begin
        mout[k] = (di && k >= 4) ? 0 : t;
        macc[k] = 0;
      end else macc[k] = t;
    end
    if (d) marmo = di & marm;
    mdv = d;
    if (h) msr = {msr[0], c};
    marm = di ? (marm ^ d) : 1'b0;
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) begin macc[k] = 0; mout[k] = 0; end
    msr = 0; marm = 0; marmo = 0; mdv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");

    // R2: lone chip edge walks through the taps; sign fixed at 0
    cyc("R2", 1, 1, 1, 0, 0, 1, 0);
    cyc("R2", 1, 1, 0, 0, 0, 1, 0);
    cyc("R2", 1, 0, 0, 0, 0, 1, 0);
    cyc("R2", 1, 1, 0, 0, 0, 1, 0);
    cyc("R2", 1, 1, 0, 0, 0, 1, 0);

    // R3/R4/R5: random patterns, dump periods of varied length
    for (int p = 0; p < 300; p++) begin
      int len;
      len = 1 + ($urandom % 20);
      for (int j = 0; j < len; j++)
        cyc("R3", $urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom % 2,
            $urandom % 2, j == len - 1, 0);
      cyc("R5", 0, 0, 0, 0, 0, 0, 0);
    end

    // R6/R7: dither mode, arms alternate across dumps
    for (int p = 0; p < 40; p++) begin
      int len;
      len = 2 + ($urandom % 12);
      for (int j = 0; j < len; j++)
        cyc("R6", 1, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, j == len - 1, 1);
    end
    cyc("R7", 1, 1, 1, 0, 1, 1, 0);
    cyc("R7", 1, 0, 1, 1, 1, 1, 0);

    // R8: full-length periods of all matches and all mismatches
    for (int j = 0; j < ML; j++) cyc("R8", 1, 0, 1, 1, 1, j == ML - 1, 0);
    chk("R8", "max", early_i, ML);
    for (int j = 0; j < ML; j++) cyc("R8", 1, 0, 1, 0, 0, j == ML - 1, 0);
    chk("R8", "min", prompt_q, -ML);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule